// File: doc/BRIEF.md
# Half-Step Clock Source Divider

This block makes the clock for one clock domain. It chooses one of five candidate clocks: a crystal, a fixed 100 MHz reference, a fixed 108 MHz clock, and two PLL VCO outputs. It then divides the chosen clock by a ratio that moves in half steps (1, 1.5, 2, 2.5, ...). The block also reports the resulting output frequency in kHz as a 32-bit value. That value is computed from the applied settings and from parameters that give the nominal input frequencies.

The candidate clocks come in as levels and are oversampled by the block's core clock. Each input passes through its own synchronizer and transition detector. A divided clock period spans d+2 transitions of the selected input, so odd counts still give a duty cycle near 50%. Software writes a source word and a divider word through a one-cycle write strobe. The written words are held as pending settings and are applied only when the current output period completes, and the counter then restarts from zero.

Top module: `halfstep_clk_gen`

## Requirements
- R1: After reset, clk_out is low and the source and divider words are both zero, so the crystal path is selected and freq_khz reads F_XTAL_KHZ.
- R2: With select field (source word bits [1:0]) equal to 0, the 108 MHz input is used only when source word bits [17:16] are both 1; any other value of those two bits selects the crystal.
- R3: Select value 2 routes the 100 MHz reference input, and freq_khz reads F_REF_KHZ.
- R4: Select value 3 routes a VCO: source word bit 8 clear picks VCO 0, set picks VCO 1. With division disabled the VCO passes at its own rate.
- R5: Select value 1 is invalid: freq_khz reads 0 and clk_out stays low. A new source word written while the invalid select is applied takes effect on the next core clock, without waiting for an output boundary.
- R6: Divider word bit 31 enables division and bits [5:0] hold d; all other divider bits are ignored. On the VCO path with division enabled, one output period spans d+2 transitions of the selected input, and freq_khz is floor(2*F_vco/(d+2)).
- R7: The divider word has no effect on the crystal, 108 MHz and reference paths: the output period stays two input transitions and the readback stays the nominal frequency.
- R8: For an odd count of d+2 transitions, the output stays high for (d+3)/2 transitions and low for (d+1)/2.
- R9: Writes with wr_addr=0 load the source word and writes with wr_addr=1 load the divider word. The new values are applied only at the end of the current output period: until then the output waveform and freq_khz keep the old settings.
- R10: The frequency division truncates toward zero (for example 2*999999/4 reads 499999).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the candidate clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_xtal | input | 1 | Crystal clock level |
| src_fix108 | input | 1 | Fixed 108 MHz clock level |
| src_ref100 | input | 1 | Fixed 100 MHz reference level |
| src_vco0 | input | 1 | VCO 0 clock level |
| src_vco1 | input | 1 | VCO 1 clock level |
| wr_en | input | 1 | Write strobe, one core cycle |
| wr_addr | input | 1 | 0 selects the source word, 1 the divider word |
| wr_data | input | 32 | Word to write |
| clk_out | output | 1 | Divided output clock |
| freq_khz | output | 32 | Output frequency in kHz from the applied settings |

## Verification
The properties assume that every candidate clock changes level at most once per core cycle and stays slower than the core clock. They also assume that each candidate input is a free-running clock, so that an output boundary is always reached and pending settings are eventually applied. The stimulus drives each candidate as a fixed-rate square wave with a half-period of one to five core cycles, changed only on the falling core edge. It keeps every candidate running for the whole test, including while another source is selected. Output periods are measured in core cycles, so each source's distinct rate shows which input was routed.

// File: rtl/halfstep_clk_pkg.sv
package halfstep_clk_pkg;

  // Width of the divide field d in the divider word
  localparam int DIV_W = 6;
  localparam int NSRC  = 5;

  // Bit positions the decode depends on
  localparam int SRCW_FIX_LO = 16;
  localparam int SRCW_VCO    = 8;
  localparam int DIVW_EN     = 31;

  typedef enum logic [1:0] {
    SEL_CRYSTAL = 2'd0,
    SEL_BAD     = 2'd1,
    SEL_REF     = 2'd2,
    SEL_VCO     = 2'd3
  } sel_e;

  typedef enum logic [2:0] {
    SRC_XTAL = 3'd0,
    SRC_F108 = 3'd1,
    SRC_R100 = 3'd2,
    SRC_VCO0 = 3'd3,
    SRC_VCO1 = 3'd4,
    SRC_NONE = 3'd5
  } src_id_e;

  // Decoded configuration, kept instead of the raw 32-bit words
  typedef struct packed {
    sel_e             sel;
    logic             fix_ok;
    logic             vco_hi;
    logic             div_en;
    logic [DIV_W-1:0] d;
  } cfg_t;

  function automatic src_id_e pick_src(cfg_t c);
    src_id_e r;
    case (c.sel)
      SEL_CRYSTAL: r = c.fix_ok ? SRC_F108 : SRC_XTAL;
      SEL_REF:     r = SRC_R100;
      SEL_VCO:     r = c.vco_hi ? SRC_VCO1 : SRC_VCO0;
      default:     r = SRC_NONE;
    endcase
    return r;
  endfunction

  // Input transitions per output period
  function automatic logic [DIV_W:0] half_steps(cfg_t c);
    logic [DIV_W:0] n;
    if (c.sel == SEL_VCO && c.div_en)
      n = {1'b0, c.d} + (DIV_W+1)'(2);
    else
      n = (DIV_W+1)'(2);
    return n;
  endfunction

endpackage

// File: rtl/hsd_edge_detect.sv
module hsd_edge_detect #(
  parameter int NSRC        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] edge_o
);

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      // SYNC_STAGES synchronizer flops plus one history flop
      logic [SYNC_STAGES:0] sh_q;
      logic [SYNC_STAGES:0] sh_d;

      always_comb sh_d = {sh_q[SYNC_STAGES-1:0], src_i[i]};

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end

      assign edge_o[i] = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hsd_halfstep_ctr.sv
module hsd_halfstep_ctr #(
  parameter int N_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           edge_i,
  input  logic [N_W-1:0] n_i,
  output logic           clk_o,
  output logic           boundary_o
);

  logic [N_W-1:0] cnt_q, cnt_d;
  logic           out_q, out_d;
  logic           primed_q, primed_d;
  logic           en;
  logic [N_W:0]   hi_len;

  // High phase length: ceil(n/2) transitions
  assign hi_len = ({1'b0, n_i} + {{N_W{1'b0}}, 1'b1}) >> 1;

  // A period ends on its last transition; the first transition after idle also starts one
  assign boundary_o = run_i & edge_i & (~primed_q | (cnt_q == n_i - 1'b1));

  assign en = ~run_i | edge_i;

  always_comb begin
    cnt_d    = cnt_q;
    out_d    = out_q;
    primed_d = primed_q;
    if (!run_i) begin
      cnt_d    = '0;
      out_d    = 1'b0;
      primed_d = 1'b0;
    end else if (edge_i) begin
      primed_d = 1'b1;
      cnt_d    = boundary_o ? '0 : cnt_q + 1'b1;
      out_d    = ({1'b0, cnt_d} < hi_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      out_q    <= 1'b0;
      primed_q <= 1'b0;
    end else if (en) begin
      cnt_q    <= cnt_d;
      out_q    <= out_d;
      primed_q <= primed_d;
    end
  end

  assign clk_o = out_q;

endmodule

// File: rtl/hsd_freq_calc.sv
module hsd_freq_calc
  import halfstep_clk_pkg::*;
#(
  parameter logic [31:0] F_XTAL_KHZ = 32'd27000,
  parameter logic [31:0] F_108_KHZ  = 32'd108000,
  parameter logic [31:0] F_REF_KHZ  = 32'd100000,
  parameter logic [31:0] F_VCO0_KHZ = 32'd1620000,
  parameter logic [31:0] F_VCO1_KHZ = 32'd999999
) (
  input  cfg_t        cfg_i,
  output logic [31:0] freq_o
);

  logic [31:0] base;
  logic [32:0] num;
  logic [32:0] den;

  always_comb begin
    base = '0;
    case (cfg_i.sel)
      SEL_CRYSTAL: base = cfg_i.fix_ok ? F_108_KHZ : F_XTAL_KHZ;
      SEL_REF:     base = F_REF_KHZ;
      SEL_VCO:     base = cfg_i.vco_hi ? F_VCO1_KHZ : F_VCO0_KHZ;
      default:     base = '0;
    endcase
  end

  assign num = {base, 1'b0};
  assign den = 33'(cfg_i.d) + 33'd2;

  always_comb begin
    if (cfg_i.sel == SEL_VCO && cfg_i.div_en)
      freq_o = 32'(num / den);
    else
      freq_o = base;
  end

endmodule

// File: rtl/halfstep_clk_gen.sv
module halfstep_clk_gen
  import halfstep_clk_pkg::*;
#(
  parameter logic [31:0] F_XTAL_KHZ  = 32'd27000,
  parameter logic [31:0] F_108_KHZ   = 32'd108000,
  parameter logic [31:0] F_REF_KHZ   = 32'd100000,
  parameter logic [31:0] F_VCO0_KHZ  = 32'd1620000,
  parameter logic [31:0] F_VCO1_KHZ  = 32'd999999,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_xtal,
  input  logic        src_fix108,
  input  logic        src_ref100,
  input  logic        src_vco0,
  input  logic        src_vco1,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic        clk_out,
  output logic [31:0] freq_khz
);

  localparam int N_W = DIV_W + 1;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  // Configuration: pending (written) and applied
  cfg_t pend_q, pend_d, act_q, act_d;
  logic act_en;
  logic run;
  logic boundary;

  always_comb begin
    pend_d = pend_q;
    if (wr_en) begin
      if (!wr_addr) begin
        pend_d.sel    = sel_e'(wr_data[1:0]);
        pend_d.fix_ok = &wr_data[SRCW_FIX_LO+1:SRCW_FIX_LO];
        pend_d.vco_hi = wr_data[SRCW_VCO];
      end else begin
        pend_d.div_en = wr_data[DIVW_EN];
        pend_d.d      = wr_data[DIV_W-1:0];
      end
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[30:18], wr_data[15:9], wr_data[7:6]};

  assign run    = (act_q.sel != SEL_BAD);
  assign act_en = boundary | ~run;
  assign act_d  = pend_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (act_en) act_q <= act_d;
    end
  end

  // Transition detection on every candidate
  logic [NSRC-1:0] src_vec, edges;
  assign src_vec = {src_vco1, src_vco0, src_ref100, src_fix108, src_xtal};

  hsd_edge_detect #(
    .NSRC        (NSRC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_ns),
    .src_i  (src_vec),
    .edge_o (edges)
  );

  src_id_e act_id;
  logic    sel_edge;
  assign act_id = pick_src(act_q);

  always_comb begin
    case (act_id)
      SRC_XTAL: sel_edge = edges[0];
      SRC_F108: sel_edge = edges[1];
      SRC_R100: sel_edge = edges[2];
      SRC_VCO0: sel_edge = edges[3];
      SRC_VCO1: sel_edge = edges[4];
      default:  sel_edge = 1'b0;
    endcase
  end

  logic [N_W-1:0] n_act;
  assign n_act = half_steps(act_q);

  hsd_halfstep_ctr #(
    .N_W (N_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_ns),
    .run_i      (run),
    .edge_i     (sel_edge),
    .n_i        (n_act),
    .clk_o      (clk_out),
    .boundary_o (boundary)
  );

  hsd_freq_calc #(
    .F_XTAL_KHZ (F_XTAL_KHZ),
    .F_108_KHZ  (F_108_KHZ),
    .F_REF_KHZ  (F_REF_KHZ),
    .F_VCO0_KHZ (F_VCO0_KHZ),
    .F_VCO1_KHZ (F_VCO1_KHZ)
  ) u_freq (
    .cfg_i  (act_q),
    .freq_o (freq_khz)
  );

endmodule

// File: rtl/halfstep_clk_gen_chk.sv
module halfstep_clk_gen_chk
  import halfstep_clk_pkg::*;
#(
  parameter logic [31:0] F_XTAL_KHZ = 32'd27000,
  parameter logic [31:0] F_108_KHZ  = 32'd108000,
  parameter logic [31:0] F_REF_KHZ  = 32'd100000,
  parameter logic [31:0] F_VCO0_KHZ = 32'd1620000,
  parameter logic [31:0] F_VCO1_KHZ = 32'd999999
) (
  input logic        clk,
  input logic        rst_n,
  input cfg_t        cfg_act,
  input logic        run,
  input logic        sel_edge,
  input logic        boundary,
  input logic        clk_out,
  input logic [31:0] freq_khz
);

  // R2: qualified 108 MHz path reads its nominal frequency
  p_fix108_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.sel == SEL_CRYSTAL && cfg_act.fix_ok) |-> (freq_khz == F_108_KHZ));

  // R4: undivided VCO reads the chosen VCO frequency
  p_vco_undiv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.sel == SEL_VCO && !cfg_act.div_en)
      |-> (freq_khz == (cfg_act.vco_hi ? F_VCO1_KHZ : F_VCO0_KHZ)));

  // R5: invalid select keeps the output low
  p_invalid_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !clk_out);

  // R6: the output only moves on a transition of the selected input
  p_out_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sel_edge) |=> $stable(clk_out));

  // R7: the reference path ignores the divider
  p_ref_undiv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_act.sel == SEL_REF) |-> (freq_khz == F_REF_KHZ));

  // R9: applied settings hold between boundaries
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> $stable(cfg_act));

  // R9: a boundary only ever falls on an input transition
  p_bound_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |-> sel_edge);

endmodule

bind halfstep_clk_gen halfstep_clk_gen_chk #(
  .F_XTAL_KHZ (F_XTAL_KHZ),
  .F_108_KHZ  (F_108_KHZ),
  .F_REF_KHZ  (F_REF_KHZ),
  .F_VCO0_KHZ (F_VCO0_KHZ),
  .F_VCO1_KHZ (F_VCO1_KHZ)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_ns),
  .cfg_act  (act_q),
  .run      (run),
  .sel_edge (sel_edge),
  .boundary (boundary),
  .clk_out  (clk_out),
  .freq_khz (freq_khz)
);

// File: tb/halfstep_clk_gen_tb.sv
`timescale 1ns/1ps
module halfstep_clk_gen_tb;

  logic        clk;
  logic        rst_n;
  logic        src_xtal, src_fix108, src_ref100, src_vco0, src_vco1;
  logic        wr_en;
  logic        wr_addr;
  logic [31:0] wr_data;
  logic        clk_out;
  logic [31:0] freq_khz;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  halfstep_clk_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_xtal   (src_xtal),
    .src_fix108 (src_fix108),
    .src_ref100 (src_ref100),
    .src_vco0   (src_vco0),
    .src_vco1   (src_vco1),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .clk_out    (clk_out),
    .freq_khz   (freq_khz)
  );

  // 50 MHz core clock
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Candidate clocks, half-periods in core cycles: xtal 5, 108 3, ref 4, vco0 2, vco1 1
  initial begin
    int cx, cf, cr, c0;
    cx = 0; cf = 0; cr = 0; c0 = 0;
    src_xtal = 0; src_fix108 = 0; src_ref100 = 0; src_vco0 = 0; src_vco1 = 0;
    forever begin
      @(negedge clk);
      cx++; cf++; cr++; c0++;
      if (cx == 5) begin cx = 0; src_xtal   = ~src_xtal;   end
      if (cf == 3) begin cf = 0; src_fix108 = ~src_fix108; end
      if (cr == 4) begin cr = 0; src_ref100 = ~src_ref100; end
      if (c0 == 2) begin c0 = 0; src_vco0   = ~src_vco0;   end
      src_vco1 = ~src_vco1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
  endtask

  task automatic wait_rise();
    logic p;
    p = clk_out;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (!p && clk_out) break;
      p = clk_out;
    end
  endtask

  // Period and high time of one output cycle, in core cycles
  task automatic measure(output int per, output int hi);
    logic p;
    wait_rise();
    per = 1; hi = 1; p = 1'b1;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (!p && clk_out) break;
      per++;
      if (clk_out) hi++;
      p = clk_out;
    end
  endtask

  typedef struct packed {
    logic [31:0] srcw;
    logic [31:0] divw;
    logic [31:0] freq;
    logic [15:0] per;
    logic [15:0] hi;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'd27000,   16'd10,  16'd5 },  // R1 crystal
    '{32'h0003_0000, 32'h0000_0000, 32'd108000,  16'd6,   16'd3 },  // R2 qualified 108
    '{32'h0001_0000, 32'h0000_0000, 32'd27000,   16'd10,  16'd5 },  // R2 one bit only
    '{32'h0000_0002, 32'h0000_0000, 32'd100000,  16'd8,   16'd4 },  // R3 reference
    '{32'h0000_0003, 32'h0000_0000, 32'd1620000, 16'd4,   16'd2 },  // R4 vco0
    '{32'h0000_0103, 32'h0000_0000, 32'd999999,  16'd2,   16'd1 },  // R4 vco1
    '{32'h0000_0103, 32'h8000_0001, 32'd666666,  16'd3,   16'd2 },  // R8 ratio 1.5
    '{32'h0000_0103, 32'h8000_0002, 32'd499999,  16'd4,   16'd2 },  // R10 truncation
    '{32'h0000_0003, 32'h8000_003F, 32'd49846,   16'd130, 16'd66},  // R6 largest d
    '{32'h0000_0003, 32'h8000_0003, 32'd648000,  16'd10,  16'd6 },  // R8 ratio 2.5
    '{32'h0000_0103, 32'h0000_0005, 32'd999999,  16'd2,   16'd1 },  // R6 enable clear
    '{32'h0003_0000, 32'h8000_0005, 32'd108000,  16'd6,   16'd3 },  // R7 108 ignores div
    '{32'h0000_0002, 32'h8000_0007, 32'd100000,  16'd8,   16'd4 },  // R7 ref ignores div
    '{32'h0000_0103, 32'h8000_0FC4, 32'd333333,  16'd6,   16'd3 }   // R6 upper bits ignored
  };

  localparam string VTAG [NV] = '{"R1", "R2", "R2", "R3", "R4", "R4", "R8",
                                  "R10", "R6", "R8", "R6", "R7", "R7", "R6"};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int per, hi, highs;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 clk_out after reset", {31'd0, clk_out}, 32'd0);
    check("R1 freq after reset", freq_khz, 32'd27000);

    // Table of settings
    for (int i = 0; i < NV; i++) begin
      write_word(1'b0, VECS[i].srcw);
      write_word(1'b1, VECS[i].divw);
      repeat (200) @(negedge clk);
      check({VTAG[i], " freq"}, freq_khz, VECS[i].freq);
      measure(per, hi);
      check({VTAG[i], " period"}, 32'(per), 32'(VECS[i].per));
      check({VTAG[i], " high"}, 32'(hi), 32'(VECS[i].hi));
    end

    // R5: invalid select
    write_word(1'b1, 32'h0000_0000);
    write_word(1'b0, 32'h0000_0001);
    repeat (40) @(negedge clk);
    check("R5 freq invalid", freq_khz, 32'd0);
    highs = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    check("R5 clk_out held low", 32'(highs), 32'd0);
    write_word(1'b0, 32'h0000_0002);
    @(negedge clk);
    check("R5 leave invalid at once", freq_khz, 32'd100000);

    // R9: change only at output boundary
    write_word(1'b0, 32'h0000_0003);
    write_word(1'b1, 32'h8000_003F);
    repeat (300) @(negedge clk);
    wait_rise();
    repeat (10) @(negedge clk);
    write_word(1'b1, 32'h8000_0000);
    repeat (10) @(negedge clk);
    check("R9 freq before boundary", freq_khz, 32'd49846);
    check("R9 high phase kept", {31'd0, clk_out}, 32'd1);
    repeat (300) @(negedge clk);
    check("R9 freq after boundary", freq_khz, 32'd1620000);
    measure(per, hi);
    check("R9 period after boundary", 32'(per), 32'd4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule